// File: doc/BRIEF.md
# Byte-Register SPI Master

This block is an SPI master that a host processor runs through six byte-wide registers: two configuration registers and four data bytes. Together the data bytes form one 32-bit shift word. Software picks the idle clock level, the sampling phase, a transfer length of 8, 16, 24 or 32 bits, the bit order, one of four serial clock rates, and whether a select line is framed automatically or held by software. Writing the top data byte is the start command. Software then polls a busy bit, and when that bit clears it reads the received bits back from the same data bytes.

Active bits always sit at the top of the 32-bit word. A short transfer uses only the upper N bits, and the received bits land in those same positions. One of eight active-low select lines is driven, and it comes from a 3-bit select field. An active-low interrupt line from the attached device is synchronised and latched into a status bit. When enabled, the latched status is routed to one of four request outputs.

Top module: `spi_host_regs`

## Requirements
- R1: After reset, every register reads 0, all select lines are high, the serial clock is low, the busy bit is 0 and no request output is active.
- R2: Address 0 holds configuration A, laid out as D7 idle clock level, D6 phase, D5-D4 length code, D3 manual select, D2-D0 select number. Address 1 holds configuration B, laid out as D7-D6 request route, D5-D4 rate code, D3 interrupt enable, D2 LSB-first, D1 interrupt status, D0 busy. Addresses 2 to 5 hold data bytes 0 to 3, and byte 3 is bits 31-24. All writable fields read back as written.
- R3: A write to address 5 while idle starts a transfer. Busy reads 1 from the next cycle for exactly 2·N·H clock cycles, where N = 8·(length code + 1) and H = FAST_HALF·2^(3 − rate code). Rate code 3 is the fastest.
- R4: Only bits 31 down to 32−N are sent. MSB-first order (D2=0) sends bit 31 first and then works down. LSB-first order sends bit 32−N first and then works up.
- R5: When the transfer ends, the received bits occupy bits 31 to 32−N. In MSB-first order the first received bit goes to bit 31. In LSB-first order it goes to bit 32−N. Bits below 32−N keep their written values.
- R6: With phase 0, outgoing data is valid before each leading clock edge and incoming data is sampled on it. With phase 1, outgoing data changes on the leading edge and incoming data is sampled on the trailing edge. Between transfers, and right after one, the clock rests at the idle level from D7.
- R7: When manual select is 0, only the selected line is low, and only while busy. All lines are high when idle.
- R8: When manual select is 1, the selected line stays low whatever the busy state, and the other lines stay high.
- R9: Any write while busy is ignored, including a write to address 5. No second transfer starts and no configuration changes.
- R10: A low level on the device interrupt input sets the status bit (D1 of address 1). Writing 1 to D1 clears the bit. Writing 0 to D1 leaves it unchanged.
- R11: Request output number equal to the route field is high exactly when the status bit and the enable bit are both 1. All other request outputs stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_addr | input | 3 | Register address |
| host_wr | input | 1 | Write strobe, one cycle per write |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data for host_addr (combinational) |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_sel_n | output | 8 | Active-low select lines |
| dev_irq_n | input | 1 | Active-low interrupt from the device |
| irq_out | output | 4 | Routed interrupt requests |

## Verification
Register writes take effect at the capturing edge, so a read at the falling edge that follows already shows the new value. The busy bit and the framed select line go active at that same edge. They stay active for exactly 2·N·H cycles, and the bench counts them cycle by cycle against its own formula. The received word is written at the edge where busy falls, so the bench reads the data bytes only after it first sees busy low. The interrupt status passes through a two-stage synchroniser, so the bench holds the input low for several cycles before it reads. The device model drives and samples on falling system clock edges only, which keeps it clear of the design's registers.

// File: rtl/spi_host_pkg.sv
// Shared constants for the register-driven SPI master.
// Assumes a 3-bit register address and byte-wide registers.
package spi_host_pkg;
    localparam int WORD_W = 32;
    localparam int SS_W   = 3;
    localparam int NSEL   = 1 << SS_W;
    localparam int NIRQ   = 4;

    localparam logic [2:0] ADDR_CFGA = 3'd0;
    localparam logic [2:0] ADDR_CFGB = 3'd1;
    localparam logic [2:0] ADDR_DAT0 = 3'd2;
    localparam logic [2:0] ADDR_DAT3 = 3'd5;

    typedef struct packed {
        logic            idle_hi;
        logic            late_phase;
        logic [1:0]      len_code;
        logic            manual;
        logic [SS_W-1:0] ss;
    } cfga_t;
endpackage

// File: rtl/spi_rate_div.sv
// Half-period tick generator for the serial clock.
// Rate code 3 gives FAST_HALF system cycles per half period, and each
// step down doubles that. Holds its count while run is low.
module spi_rate_div #(
    parameter int FAST_HALF = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [1:0] rate,
    output logic       tick
);
    localparam int CW = $clog2(FAST_HALF * 8 + 1);

    logic [CW-1:0] half_len;
    logic [CW-1:0] cnt_q;

    // Half-period length picked by the rate code.
    always_comb half_len = CW'(FAST_HALF) << (2'd3 - rate);

    assign tick = run && (cnt_q == '0);

    // Count down once per cycle while running; reload on each tick or when idle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!run || tick)
            cnt_q <= half_len - CW'(1);
        else
            cnt_q <= cnt_q - CW'(1);
    end
endmodule

// File: rtl/spi_shift_core.sv
// Shift engine that runs on a top-aligned field of 8..32 bits.
// Assumes cpol/cpha/lsb_first/len stay stable while busy; the register
// block enforces this. fin pulses on the edge that ends a transfer, and
// next_word is valid in that cycle.
module spi_shift_core
    import spi_host_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [WORD_W-1:0] load_word,
    input  logic [1:0]        len,
    input  logic              cpol,
    input  logic              cpha,
    input  logic              lsb_first,
    input  logic              tick,
    input  logic              miso,
    output logic              busy,
    output logic              sclk,
    output logic              mosi,
    output logic              fin,
    output logic [WORD_W-1:0] next_word
);
    logic [WORD_W-1:0] sh_q;
    logic [5:0]        ecnt_q;
    logic              busy_q, sclk_q, mosi_q, rxh_q;
    logic [4:0]        lo;
    logic [5:0]        last;
    logic              lead, rx_bit;

    // Lowest active bit and index of the final edge for this length.
    always_comb begin
        lo   = {~len, 3'b000};
        last = {len, 4'b1111};
    end

    // Move the active field one place, putting the new bit at the fill end.
    function automatic logic [WORD_W-1:0] step(input logic [WORD_W-1:0] w,
        input logic [4:0] low, input logic lsb, input logic rx);
        logic [WORD_W-1:0] r, rl, rr;
        r  = w;
        rl = {w[WORD_W-2:0], w[WORD_W-1]};
        rr = {w[0], w[WORD_W-1:1]};
        for (int i = 0; i < WORD_W; i++) begin
            if (!lsb) begin
                if (5'(i) == low)     r[i] = rx;
                else if (5'(i) > low) r[i] = rl[i];
            end else begin
                if (i == WORD_W - 1)   r[i] = rx;
                else if (5'(i) >= low) r[i] = rr[i];
            end
        end
        return r;
    endfunction

    // Bit currently at the send end of the active field.
    function automatic logic out_bit(input logic [WORD_W-1:0] w,
        input logic [4:0] low, input logic lsb);
        return lsb ? w[low] : w[WORD_W-1];
    endfunction

    always_comb begin
        lead      = ~ecnt_q[0];
        rx_bit    = cpha ? miso : rxh_q;
        next_word = step(sh_q, lo, lsb_first, rx_bit);
        fin       = busy_q && tick && !lead && (ecnt_q == last);
    end

    // Start, then per clock edge: toggle, sample, shift or drive per phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q <= '0; ecnt_q <= '0; busy_q <= 1'b0;
            sclk_q <= 1'b0; mosi_q <= 1'b0; rxh_q <= 1'b0;
        end else if (start) begin
            sh_q   <= load_word;
            ecnt_q <= '0;
            busy_q <= 1'b1;
            mosi_q <= out_bit(load_word, lo, lsb_first);
        end else if (busy_q && tick) begin
            sclk_q <= ~sclk_q;
            ecnt_q <= ecnt_q + 6'd1;
            if (lead) begin
                if (!cpha) rxh_q  <= miso;
                else       mosi_q <= out_bit(sh_q, lo, lsb_first);
            end else begin
                sh_q <= next_word;
                if (!cpha) mosi_q <= out_bit(next_word, lo, lsb_first);
                if (fin)   busy_q <= 1'b0;
            end
        end else if (!busy_q) begin
            sclk_q <= cpol;
        end
    end

    assign busy = busy_q;
    assign sclk = sclk_q;
    assign mosi = mosi_q;

    // R3: the edge counter never runs past the final edge of the length.
    assert_edge_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> ecnt_q <= last);
    // R6: after the final edge the clock sits at the idle level.
    assert_idle_return_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fin |=> sclk_q == $past(cpol));
endmodule

// File: rtl/spi_sel_decode.sv
// Drives the eight active-low select lines from the select number.
// Manual mode holds the line; auto mode frames it with busy.
module spi_sel_decode
    import spi_host_pkg::*;
(
    input  logic            manual,
    input  logic            busy,
    input  logic [SS_W-1:0] ss,
    output logic [NSEL-1:0] sel_n
);
    // One decoder leg per select line.
    for (genvar g = 0; g < NSEL; g++) begin : g_leg
        assign sel_n[g] = !((ss == SS_W'(g)) && (manual || busy));
    end
endmodule

// File: rtl/spi_host_regs.sv
// Register front end of the SPI master: holds both configuration bytes and
// the data word, starts a transfer on a write to the top data byte,
// blocks writes while busy, and latches the device interrupt.
// Assumes one-cycle write strobes and an asynchronous dev_irq_n.
module spi_host_regs
    import spi_host_pkg::*;
#(
    parameter int FAST_HALF = 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [2:0]      host_addr,
    input  logic            host_wr,
    input  logic [7:0]      host_wdata,
    output logic [7:0]      host_rdata,
    output logic            spi_sclk,
    output logic            spi_mosi,
    input  logic            spi_miso,
    output logic [NSEL-1:0] spi_sel_n,
    input  logic            dev_irq_n,
    output logic [NIRQ-1:0] irq_out
);
    cfga_t             cfga_q;
    logic [1:0]        route_q, rate_q;
    logic              hwen_q, lsbf_q, hwint_q;
    logic [WORD_W-1:0] dat_q;
    logic [1:0]        irq_sync_q;
    logic              busy, fin, tick, wr_ok, start;
    logic [WORD_W-1:0] next_word;

    assign wr_ok = host_wr && !busy;
    assign start = wr_ok && (host_addr == ADDR_DAT3);

    // Two-stage synchroniser for the device interrupt.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_sync_q <= 2'b11;
        else        irq_sync_q <= {irq_sync_q[0], dev_irq_n};
    end

    // Register writes, result capture and interrupt status latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfga_q <= '0; route_q <= '0; rate_q <= '0;
            hwen_q <= 1'b0; lsbf_q <= 1'b0; hwint_q <= 1'b0; dat_q <= '0;
        end else begin
            if (wr_ok) begin
                if (host_addr == ADDR_CFGA) cfga_q <= cfga_t'(host_wdata);
                if (host_addr == ADDR_CFGB) begin
                    route_q <= host_wdata[7:6];
                    rate_q  <= host_wdata[5:4];
                    hwen_q  <= host_wdata[3];
                    lsbf_q  <= host_wdata[2];
                    if (host_wdata[1]) hwint_q <= 1'b0;
                end
                for (int b = 0; b < 4; b++)
                    if (host_addr == ADDR_DAT0 + 3'(b)) dat_q[b*8 +: 8] <= host_wdata;
            end
            if (fin) dat_q <= next_word;
            if (!irq_sync_q[1]) hwint_q <= 1'b1;
        end
    end

    // Read multiplexer.
    always_comb begin
        case (host_addr)
            ADDR_CFGA: host_rdata = cfga_q;
            ADDR_CFGB: host_rdata = {route_q, rate_q, hwen_q, lsbf_q, hwint_q, busy};
            3'd2:      host_rdata = dat_q[7:0];
            3'd3:      host_rdata = dat_q[15:8];
            3'd4:      host_rdata = dat_q[23:16];
            ADDR_DAT3: host_rdata = dat_q[31:24];
            default:   host_rdata = 8'h00;
        endcase
    end

    // Interrupt request routing, one leg per output.
    for (genvar g = 0; g < NIRQ; g++) begin : g_irq
        assign irq_out[g] = hwint_q && hwen_q && (route_q == 2'(g));
    end

    spi_rate_div #(.FAST_HALF(FAST_HALF)) i_div (
        .clk(clk), .rst_n(rst_n), .run(busy), .rate(rate_q), .tick(tick));

    spi_shift_core i_core (
        .clk(clk), .rst_n(rst_n), .start(start),
        .load_word({host_wdata, dat_q[23:0]}), .len(cfga_q.len_code),
        .cpol(cfga_q.idle_hi), .cpha(cfga_q.late_phase), .lsb_first(lsbf_q),
        .tick(tick), .miso(spi_miso), .busy(busy), .sclk(spi_sclk),
        .mosi(spi_mosi), .fin(fin), .next_word(next_word));

    spi_sel_decode i_sel (
        .manual(cfga_q.manual), .busy(busy), .ss(cfga_q.ss), .sel_n(spi_sel_n));

    // R9: configuration A does not change under a write issued while busy.
    assert_cfg_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy && host_wr |=> $stable(cfga_q));
    // R10: the status bit stays set unless software writes 1 to clear it.
    assert_status_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        hwint_q && !(wr_ok && host_addr == ADDR_CFGB && host_wdata[1]) |=> hwint_q);
    // R11: at most one request, and only when enabled with status set.
    assert_irq_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(irq_out) && ((irq_out != '0) -> (hwen_q && hwint_q)));
    // R7: in auto mode every line is released while idle.
    assert_auto_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !cfga_q.manual && !busy |-> &spi_sel_n);
    // R8: in manual mode exactly one line is held low.
    assert_manual_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cfga_q.manual |-> $countones(~spi_sel_n) == 1);
endmodule

// File: tb/test_spi_host_regs.sv
module test_spi_host_regs;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] h_addr = 3'd0;
    logic       h_wr = 1'b0;
    logic [7:0] h_wd = 8'h00;
    logic [7:0] h_rd;
    logic       sclk, mosi;
    logic       miso = 1'b0;
    logic [7:0] sel_n;
    logic       irq_n = 1'b1;
    logic [3:0] irq_out;

    int total = 0;
    int bad = 0;

    // device model state
    logic        s_cpol = 1'b0, s_cpha = 1'b0, prev_sclk = 1'b0;
    logic [31:0] s_r = '0, s_m = '0;
    int          s_k = 0;

    spi_host_regs i_spi_host_regs (
        .clk(clk), .rst_n(rst_n), .host_addr(h_addr), .host_wr(h_wr),
        .host_wdata(h_wd), .host_rdata(h_rd), .spi_sclk(sclk), .spi_mosi(mosi),
        .spi_miso(miso), .spi_sel_n(sel_n), .dev_irq_n(irq_n), .irq_out(irq_out));

    always #2 clk = ~clk;

    // Device model: reacts to serial clock edges, seen on falling system edges.
    always @(negedge clk) begin
        if (rst_n && sclk != prev_sclk) begin
            if (sclk != s_cpol) begin
                if (!s_cpha) begin if (s_k < 32) s_m[s_k] = mosi; end
                else if (s_k < 32) miso = s_r[s_k];
            end else begin
                if (!s_cpha) begin s_k++; if (s_k < 32) miso = s_r[s_k]; end
                else begin if (s_k < 32) s_m[s_k] = mosi; s_k++; end
            end
        end
        prev_sclk = sclk;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); h_wr = 1'b1; h_addr = a; h_wd = d;
        @(negedge clk); h_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        h_addr = a; #1; d = h_rd;
    endtask

    task automatic rd_word(output logic [31:0] w);
        logic [7:0] b;
        for (int i = 0; i < 4; i++) begin rd(3'(2 + i), b); w[i*8 +: 8] = b; end
    endtask

    function automatic logic [31:0] exp_rx(input logic [31:0] w, input logic [1:0] len,
        input logic lsb, input logic [31:0] r);
        int n = 8 * (int'(len) + 1);
        logic [31:0] e = w;
        for (int k = 0; k < n; k++)
            if (!lsb) e[31 - k] = r[k]; else e[32 - n + k] = r[k];
        return e;
    endfunction

    function automatic logic [31:0] exp_tx(input logic [31:0] w, input logic [1:0] len,
        input logic lsb);
        int n = 8 * (int'(len) + 1);
        logic [31:0] e = '0;
        for (int k = 0; k < n; k++)
            e[k] = lsb ? w[32 - n + k] : w[31 - k];
        return e;
    endfunction

    // One automatic-select transfer, with optional writes issued while busy.
    task automatic xfer(input logic cpol, input logic cpha, input logic [1:0] len,
        input logic lsb, input logic [1:0] rate, input logic [2:0] ss,
        input logic [31:0] w, input bit poke);
        logic [7:0] v;
        logic [31:0] got;
        logic [7:0] cfga;
        int n, expn, nb;
        bit sel_ok;
        nb = 8 * (int'(len) + 1);
        expn = 2 * nb * (1 << (3 - int'(rate)));
        cfga = {cpol, cpha, len, 1'b0, ss};
        wr(3'd1, {2'b00, rate, 1'b0, lsb, 2'b00});
        wr(3'd0, cfga);
        @(negedge clk); @(negedge clk);
        s_cpol = cpol; s_cpha = cpha; s_k = 0; s_m = '0; s_r = $urandom;
        miso = cpha ? 1'b0 : s_r[0];
        wr(3'd2, w[7:0]); wr(3'd3, w[15:8]); wr(3'd4, w[23:16]);
        wr(3'd5, w[31:24]);
        rd(3'd1, v);
        chk(v[0] == 1'b1, "R3 busy set after start", {31'd0, v[0]}, 32'd1);
        n = 0; sel_ok = 1'b1;
        while (!sel_n[ss] && n < 5000) begin
            if (sel_n != ~(8'b1 << ss)) sel_ok = 1'b0;
            n++;
            if (poke && n == 4) begin h_wr = 1'b1; h_addr = 3'd0; h_wd = 8'hff; end
            if (poke && n == 5) begin h_addr = 3'd5; h_wd = 8'h3c; end
            if (poke && n == 6) h_wr = 1'b0;
            @(negedge clk);
        end
        chk(n == expn, "R3 busy length", n, expn);
        chk(sel_ok && sel_n == 8'hff, "R7 framed select", {24'd0, sel_n}, 32'hff);
        chk(sclk == cpol, "R6 clock idle after transfer", {31'd0, sclk}, {31'd0, cpol});
        rd(3'd1, v);
        chk(v[0] == 1'b0, "R3 busy clear after end", {31'd0, v[0]}, 32'd0);
        chk(s_m == exp_tx(w, len, lsb), "R4/R6 sent bits", s_m, exp_tx(w, len, lsb));
        rd_word(got);
        chk(got == exp_rx(w, len, lsb, s_r), "R5/R6 received word", got, exp_rx(w, len, lsb, s_r));
        if (poke) begin
            rd(3'd0, v);
            chk(v == cfga, "R9 config held through busy writes", {24'd0, v}, {24'd0, cfga});
            repeat (20) @(negedge clk);
            chk(sel_n == 8'hff, "R9 no second transfer", {24'd0, sel_n}, 32'hff);
        end
    endtask

    initial begin
        logic [7:0] v;
        logic [31:0] w;
        logic [31:0] seedv;
        seedv = $urandom(32'd2024);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        rd_word(w);
        chk(w == 0, "R1 data reset", w, 0);
        rd(3'd0, v); chk(v == 0, "R1 config A reset", {24'd0, v}, 0);
        rd(3'd1, v); chk(v == 0, "R1 config B reset", {24'd0, v}, 0);
        chk(sel_n == 8'hff && sclk == 1'b0 && irq_out == 4'd0, "R1 pins reset",
            {19'd0, sclk, irq_out, sel_n}, 32'h0000_00ff);
        // R2: readback
        wr(3'd0, 8'hb5); rd(3'd0, v);
        chk(v == 8'hb5, "R2 config A readback", {24'd0, v}, 32'hb5);
        wr(3'd1, 8'h74); rd(3'd1, v);
        chk(v == 8'h74, "R2 config B readback", {24'd0, v}, 32'h74);
        wr(3'd4, 8'h5a); rd(3'd4, v);
        chk(v == 8'h5a, "R2 data byte readback", {24'd0, v}, 32'h5a);
        // R8: manual select
        wr(3'd0, 8'h0d);
        chk(sel_n == 8'hdf, "R8 manual select held", {24'd0, sel_n}, 32'hdf);
        repeat (10) @(negedge clk);
        chk(sel_n == 8'hdf, "R8 manual select stays", {24'd0, sel_n}, 32'hdf);
        wr(3'd0, 8'h00);
        // directed corners: each length, both orders, fastest/slowest rate
        xfer(1'b0, 1'b0, 2'd0, 1'b0, 2'd3, 3'd0, 32'hA5C3_0F96, 1'b0);
        xfer(1'b1, 1'b1, 2'd3, 1'b1, 2'd3, 3'd7, 32'h1234_5678, 1'b0);
        xfer(1'b0, 1'b1, 2'd2, 1'b0, 2'd0, 3'd3, 32'hDEAD_BEEF, 1'b0);
        xfer(1'b1, 1'b0, 2'd1, 1'b1, 2'd1, 3'd4, 32'h8001_7FFE, 1'b0);
        // R9: writes while busy
        xfer(1'b0, 1'b0, 2'd3, 1'b0, 2'd0, 3'd2, 32'hCAFE_F00D, 1'b1);
        // random transfers
        for (int i = 0; i < 20; i++) begin
            w = $urandom;
            xfer(1'($urandom), 1'($urandom), 2'($urandom), 1'($urandom),
                 2'($urandom), 3'($urandom), w, 1'b0);
        end
        // R10/R11: interrupt latch and routing
        wr(3'd1, 8'h80);
        @(negedge clk); irq_n = 1'b0;
        repeat (4) @(negedge clk); irq_n = 1'b1;
        repeat (4) @(negedge clk);
        rd(3'd1, v);
        chk(v[1] == 1'b1, "R10 status latched", {31'd0, v[1]}, 32'd1);
        chk(irq_out == 4'd0, "R11 request gated off", {28'd0, irq_out}, 0);
        wr(3'd1, 8'h88);
        chk(irq_out == 4'b0100, "R11 request routed", {28'd0, irq_out}, 32'h4);
        wr(3'd1, 8'h48);
        chk(irq_out == 4'b0010, "R11 request rerouted", {28'd0, irq_out}, 32'h2);
        rd(3'd1, v);
        chk(v[1] == 1'b1, "R10 write 0 keeps status", {31'd0, v[1]}, 32'd1);
        wr(3'd1, 8'h4a);
        rd(3'd1, v);
        chk(v[1] == 1'b0 && irq_out == 4'd0, "R10 write 1 clears", {27'd0, irq_out, v[1]}, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog R3 actual=%0d expected=%0d", 150000, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule